// File: doc/BRIEF.md
# PCI Clock Stop Gate

This block sits between a PCI-rate clock waveform and a set of PCI clock output pins. It passes the waveform to a group of gated outputs, and stops and restarts that group cleanly in response to an asynchronous, active-low stop request. A separate free-running output keeps following the PCI waveform whatever the stop request does. Each gated output also has a static enable bit from configuration. An output whose bit is clear stays low.

All logic runs on the fast internal clock `clk`. The PCI-rate waveform `pci_in` is produced upstream, synchronously to `clk`, and has a high and a low phase of at least one `clk` cycle each. The block samples `pci_in` and detects its rising and falling edges. The stop request passes through a two-flop synchronizer first. The run/halt decision and the enable bits are updated only at a PCI falling edge. Stopped outputs therefore park low, and a restarted clock always begins with a complete high phase.

After every restart, and after reset, the gated group delivers at least `MIN_RUN` PCI pulses before it may stop again. A stop request that arrives inside this window is held pending and takes effect when the window ends.

Top module: `pci_clk_stop`

## Requirements
- R1: While `rst_n` is low, all outputs are low. Reset leaves the gate in the running state with the run window just begun and the latched enables cleared, so the first PCI high phase after reset produces no gated or free pulse.
- R2: The stop request (`stop_req_n` = 0) passes through a two-flop synchronizer and is evaluated at each PCI falling edge. If it is active there and the run window is complete, the gated group produces no pulse from the next PCI high phase onward. The high phase in which the request was raised still completes in full.
- R3: A halted gated output stays low for whole PCI cycles. A gated output only falls on a `clk` edge at which `pci_in` was low in the preceding cycle.
- R4: When the request is seen inactive at a PCI falling edge while the group is halted, the group pulses again on the very next PCI high phase. Every gated pulse starts at a PCI rising edge and lasts the full high phase.
- R5: After reset and after each restart, the gated group does not halt until at least `MIN_RUN` (default 10) PCI rising edges have passed in the running state.
- R6: A stop request seen during the run window is remembered. At the first falling edge where the window is complete, the group halts even if the request has since been withdrawn. If the request is then inactive, the group restarts at the following falling edge, so exactly one pulse is dropped.
- R7: `pci_free_o` reproduces every PCI high phase while its latched enable is 1, independent of the stop request.
- R8: A gated output whose latched enable bit (bit i of `out_en` for `pci_gated_o[i]`) is 0 stays low.
- R9: The enable bits and the run/halt state change only at a PCI falling edge. A change on `out_en` or `free_en` during a high phase first affects the next high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast internal clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| pci_in | input | 1 | PCI-rate clock waveform, synchronous to clk |
| stop_req_n | input | 1 | Asynchronous active-low stop request for the gated group |
| out_en | input | N_GATED | Per-output enable of the gated group, 1 = enabled |
| free_en | input | 1 | Enable of the free-running output |
| pci_gated_o | output | N_GATED | Gated PCI clock outputs |
| pci_free_o | output | 1 | Free-running PCI clock output |

## Verification
A wrong run/halt state shows at the ports within one PCI high phase. Whole pulses appear or vanish on every enabled gated output at once, and the free output shows no difference. A run-window counter that is off by one shows only at the moment a stop meets the window end. It appears as a pulse one PCI cycle too many or too few, so the stimulus lines up requests exactly against that boundary, both with the request held and with it withdrawn. A latched-enable error shows on a single output, one PCI cycle after the configuration change. A glitch from updating the gate in the wrong phase shows as a gated edge that does not line up with a PCI edge.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic {
    GATE_HALT = 1'b0,
    GATE_RUN  = 1'b1
  } gate_state_e;

  // Saturating step of the run-window pulse counter.
  function automatic int unsigned window_step(int unsigned count, int unsigned limit);
    return (count >= limit) ? limit : count + 1;
  endfunction

  // A halt is taken when a request (live or pending) meets a finished window.
  function automatic logic halt_now(logic req_live, logic req_pend, logic window_done);
    return (req_live | req_pend) & window_done;
  endfunction

endpackage

// File: rtl/pcs_sync.sv
module pcs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
#(
  parameter int          N_GATED = 5,
  parameter int unsigned MIN_RUN = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_evt,
  input  logic               fall_evt,
  input  logic               stop_seen,
  input  logic [N_GATED-1:0] en_in,
  input  logic               free_en_in,
  output logic               run_q,
  output logic               pend_q,
  output logic [N_GATED-1:0] en_q,
  output logic               free_en_q
);
  localparam int CNT_W = $clog2(MIN_RUN + 1);

  gate_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_step;
  logic             win_done;

  assign cnt_step = CNT_W'(window_step(32'(cnt_q), MIN_RUN));
  assign win_done = (32'(cnt_q) >= MIN_RUN);
  assign run_q    = (state_q == GATE_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= GATE_RUN;
      cnt_q     <= '0;
      pend_q    <= 1'b0;
      en_q      <= '0;
      free_en_q <= 1'b0;
    end else begin
      if (rise_evt && state_q == GATE_RUN) cnt_q <= cnt_step;
      if (fall_evt) begin
        en_q      <= en_in;
        free_en_q <= free_en_in;
        if (state_q == GATE_RUN) begin
          if (halt_now(stop_seen, pend_q, win_done)) begin
            state_q <= GATE_HALT;
            pend_q  <= 1'b0;
          end else if (stop_seen) begin
            pend_q <= 1'b1;
          end
        end else if (!stop_seen) begin
          state_q <= GATE_RUN;
          cnt_q   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/pcs_outs.sv
module pcs_outs #(
  parameter int N_GATED = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pci_in,
  input  logic               run_q,
  input  logic [N_GATED-1:0] en_q,
  input  logic               free_en_q,
  output logic [N_GATED-1:0] gated_o,
  output logic               free_o
);
  for (genvar g = 0; g < N_GATED; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) gated_o[g] <= 1'b0;
      else        gated_o[g] <= pci_in & run_q & en_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) free_o <= 1'b0;
    else        free_o <= pci_in & free_en_q;
  end
endmodule

// File: rtl/pci_clk_stop.sv
module pci_clk_stop #(
  parameter int          N_GATED     = 5,
  parameter int unsigned MIN_RUN     = 10,
  parameter int          SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pci_in,
  input  logic               stop_req_n,
  input  logic [N_GATED-1:0] out_en,
  input  logic               free_en,
  output logic [N_GATED-1:0] pci_gated_o,
  output logic               pci_free_o
);
  logic               pci_d;
  logic               rise_evt;
  logic               fall_evt;
  logic               stop_seen;
  logic               run_q;
  logic               pend_q;
  logic [N_GATED-1:0] en_q;
  logic               free_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pci_d <= 1'b0;
    else        pci_d <= pci_in;
  end

  assign rise_evt = pci_in & ~pci_d;
  assign fall_evt = ~pci_in & pci_d;

  pcs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (~stop_req_n),
    .sync_out (stop_seen)
  );

  pcs_ctrl #(.N_GATED(N_GATED), .MIN_RUN(MIN_RUN)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .stop_seen  (stop_seen),
    .en_in      (out_en),
    .free_en_in (free_en),
    .run_q      (run_q),
    .pend_q     (pend_q),
    .en_q       (en_q),
    .free_en_q  (free_en_q)
  );

  pcs_outs #(.N_GATED(N_GATED)) u_outs (
    .clk       (clk),
    .rst_n     (rst_n),
    .pci_in    (pci_in),
    .run_q     (run_q),
    .en_q      (en_q),
    .free_en_q (free_en_q),
    .gated_o   (pci_gated_o),
    .free_o    (pci_free_o)
  );
endmodule

// File: rtl/pci_clk_stop_chk.sv
module pci_clk_stop_chk #(
  parameter int          N_GATED = 5,
  parameter int unsigned MIN_RUN = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pci_in,
  input logic               rise_evt,
  input logic               fall_evt,
  input logic               stop_seen,
  input logic               run_q,
  input logic               pend_q,
  input logic [N_GATED-1:0] en_q,
  input logic               free_en_q,
  input logic [N_GATED-1:0] pci_gated_o,
  input logic               pci_free_o
);
  logic        run_prev;
  int unsigned seen_pulses;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_prev    <= 1'b1;
      seen_pulses <= 0;
    end else begin
      run_prev <= run_q;
      if (run_q && !run_prev)
        seen_pulses <= rise_evt ? 1 : 0;
      else if (run_q && rise_evt && seen_pulses < MIN_RUN)
        seen_pulses <= seen_pulses + 1;
    end
  end

  // R4
  gate_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(pci_gated_o & ~$past(pci_gated_o)) |-> $past(rise_evt));

  // R3
  park_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(~pci_gated_o & $past(pci_gated_o)) |-> !$past(pci_in));

  // R9
  gate_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(run_q) || !$stable(en_q) || !$stable(free_en_q)) |-> $past(fall_evt));

  // R5
  min_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> (seen_pulses >= MIN_RUN));

  // R2
  halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> ($past(stop_seen) || $past(pend_q)));

  // R8
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_gated_o & ~$past(en_q)) == '0);

  // R7
  free_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pci_in) && $past(free_en_q)) |-> pci_free_o);
endmodule

bind pci_clk_stop pci_clk_stop_chk #(.N_GATED(N_GATED), .MIN_RUN(MIN_RUN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pci_in      (pci_in),
  .rise_evt    (rise_evt),
  .fall_evt    (fall_evt),
  .stop_seen   (stop_seen),
  .run_q       (run_q),
  .pend_q      (pend_q),
  .en_q        (en_q),
  .free_en_q   (free_en_q),
  .pci_gated_o (pci_gated_o),
  .pci_free_o  (pci_free_o)
);

// File: tb/sim_pci_clk_stop.sv
module sim_pci_clk_stop;
  localparam int N   = 5;
  localparam int MIN = 10;
  localparam int WD_CYCLES = 200000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pci_in;
  logic         stop_req_n;
  logic [N-1:0] out_en;
  logic         free_en;
  logic [N-1:0] pci_gated_o;
  logic         pci_free_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  logic         m_run;
  int           m_cnt;
  logic         m_pend;
  logic [N-1:0] m_en;
  logic         m_fen;

  logic [N:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  pci_clk_stop #(.N_GATED(N), .MIN_RUN(MIN)) u0 (
    .clk(clk), .rst_n(rst_n), .pci_in(pci_in), .stop_req_n(stop_req_n),
    .out_en(out_en), .free_en(free_en),
    .pci_gated_o(pci_gated_o), .pci_free_o(pci_free_o)
  );

  task automatic check(input string tag, input logic [N:0] act, input logic [N:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got gated=%b free=%b, expected gated=%b free=%b at %0t",
               tag, act[N-1:0], act[N], exp[N-1:0], exp[N], $time);
    end
  endtask

  // Model of one PCI cycle: rising edge counts, falling edge decides.
  task automatic model_step(input logic stp, input logic [N-1:0] en, input logic fen);
    if (m_run) m_cnt = (m_cnt < MIN) ? m_cnt + 1 : MIN;
    if (m_run) begin
      if ((stp || m_pend) && m_cnt >= MIN) begin m_run = 1'b0; m_pend = 1'b0; end
      else if (stp) m_pend = 1'b1;
    end else if (!stp) begin
      m_run = 1'b1; m_cnt = 0;
    end
    m_en  = en;
    m_fen = fen;
  endtask

  // Driver: one PCI cycle, 4 clk high and 4 clk low, starting at a negedge.
  task automatic pci_cycle(input logic stp, input logic [N-1:0] en, input logic fen,
                           input string tag);
    exp_q.push_back({m_fen, (m_run ? m_en : {N{1'b0}})});
    tag_q.push_back(tag);
    stop_req_n = ~stp;
    out_en     = en;
    free_en    = fen;
    pci_in     = 1'b1;
    model_step(stp, en, fen);
    repeat (4) @(negedge clk);
    pci_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Monitor: compares each high phase, then the low phase, against the queue.
  initial begin
    forever begin
      logic [N:0] e;
      string      t;
      @(posedge pci_in);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      @(negedge clk);
      check(t, {pci_free_o, pci_gated_o}, e);
      repeat (2) @(negedge clk);
      check({t, " full-width"}, {pci_free_o, pci_gated_o}, e);
      repeat (3) @(negedge clk);
      check({t, " R3 low phase"}, {pci_free_o, pci_gated_o}, '0);
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pci_in = 1'b0; stop_req_n = 1'b1; out_en = '0; free_en = 1'b0;
    m_run = 1'b1; m_cnt = 0; m_pend = 1'b0; m_en = '0; m_fen = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 reset", {pci_free_o, pci_gated_o}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: first phase silent (enables cleared), then R5 window fills
    pci_cycle(1'b0, '1, 1'b1, "R1");
    for (int i = 0; i < 11; i++) pci_cycle(1'b0, '1, 1'b1, "R5");
    // R2 stop with window met; R7 free output keeps running
    for (int i = 0; i < 4; i++) pci_cycle(1'b1, '1, 1'b1, "R2 R7");
    // R3 release phase still parked, then R4 restart
    pci_cycle(1'b0, '1, 1'b1, "R3");
    for (int i = 0; i < 3; i++) pci_cycle(1'b0, '1, 1'b1, "R4");
    // R6 short request inside the window is kept pending
    for (int i = 0; i < 2; i++) pci_cycle(1'b1, '1, 1'b1, "R6");
    for (int i = 0; i < 12; i++) pci_cycle(1'b0, '1, 1'b1, "R6");
    // R5 held request must wait for the full window
    for (int i = 0; i < 14; i++) pci_cycle(1'b1, '1, 1'b1, "R5");
    for (int i = 0; i < 3; i++) pci_cycle(1'b0, '1, 1'b1, "R4");
    // R8 disabled lanes stay low; R9 new enables apply one PCI cycle later
    pci_cycle(1'b0, 5'b10101, 1'b1, "R9");
    for (int i = 0; i < 2; i++) pci_cycle(1'b0, 5'b10101, 1'b1, "R8");
    pci_cycle(1'b0, 5'b01010, 1'b0, "R9");
    for (int i = 0; i < 2; i++) pci_cycle(1'b0, 5'b01010, 1'b0, "R8 R7");
    pci_cycle(1'b0, '1, 1'b1, "R9");
    pci_cycle(1'b0, '1, 1'b1, "R9");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2: got %0d unchecked phases, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule